// File: doc/BRIEF.md
# Fine-timestamp TTL output serializer

This block drives one digital line through an 8-slot parallel word that a downstream serializer shifts out over one cycle. A level change can therefore land between clock edges instead of only at an edge. A command port carries a strobe, an address, a data value and a 3-bit fine timestamp. A strobed write to the level address sets a new pin level. In the next cycle's word, every slot from the one the fine timestamp names onward carries the new level, and the earlier slots keep the old level. In later cycles the whole word holds the new level.

A strobed write to the enable address loads the output-enable flag from data bit 0. Writes to any other address have no effect. Coarse timing, queuing and the physical serializer sit outside this block.

Top module: `fine_ttl_out`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `ser_word` becomes 0x00 and `out_en` becomes 0.
- R2: A strobed write to address 0 with fine timestamp F and new level L = `cmd_data[0]` changes `ser_word` one cycle after the strobe cycle. In that word, bit i (bit 0 is the earliest slot) equals the previous level for i < F and equals L for i >= F. For example, a rising change at F = 3 gives 0xF8.
- R3: In any cycle after a cycle with no level write, all 8 bits of `ser_word` equal the current level (0xFF or 0x00).
- R4: A change at fine timestamp 0 replaces the whole word at once. For example, a falling change gives 0x00.
- R5: A rising change at fine timestamp 7 gives 0x80, with only the latest slot at the new level.
- R6: A strobe held active over several cycles with the same address-0 data and timestamp causes only one transition. The following words are all at the new level.
- R7: A strobed write to address 1 loads `out_en` from `cmd_data[0]`, visible one cycle after the strobe. `out_en` is not changed by level writes.
- R8: A strobed write to address 2 or 3 changes neither the line level nor `out_en`. A write to address 1 does not change the line level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_stb | input | 1 | Command strobe, one write per high cycle |
| cmd_addr | input | 2 | 0 = line level, 1 = output enable, others ignored |
| cmd_data | input | 2 | Bit 0 is the level or enable value |
| cmd_fine | input | 3 | Slot at which a level change takes effect |
| ser_word | output | 8 | Parallel word for the serializer, bit 0 earliest |
| out_en | output | 1 | Output-enable flag |

## Verification
A wrong held level shows up in the first word after any cycle without a write, because the whole word repeats the stored level. It also shows up in the early slots of the next transition word. A slot mask that is off by one moves the boundary by one bit in the word that follows the strobe, so each fine value is checked in both directions. An enable flag or level that a stray address corrupts is visible on `out_en` or `ser_word` in the very next cycle.

// File: rtl/fine_ttl_pkg.sv
// Package: shared widths and command addresses for the fine-timestamp output.
// Assumes a power-of-two slot count derived from the fine timestamp width.
package fine_ttl_pkg;
    localparam int FINE_W = 3;
    localparam int SLOTS  = 1 << FINE_W;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        CMD_LEVEL  = 2'd0,
        CMD_ENABLE = 2'd1
    } cmd_addr_e;
endpackage

// File: rtl/fine_slot_mask.sv
// Module: builds a thermometer mask that is 1 for every slot at or after
// the fine timestamp. Purely combinational; assumes SLOTS == 2**FINE_W.
module fine_slot_mask #(
    parameter int FINE_W = 3,
    localparam int SLOTS = 1 << FINE_W
) (
    input  logic [FINE_W-1:0] fine,
    output logic [SLOTS-1:0]  at_or_after
);
    // One comparator per slot: slot i takes the new level when i >= fine.
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        assign at_or_after[i] = (fine <= FINE_W'(i));
    end
endmodule

// File: rtl/level_word_reg.sv
// Module: holds the line level and the registered serializer word. On a
// level write the word mixes old and new level by the slot mask; otherwise
// the word replicates the stored level. Synchronous active-low reset.
module level_word_reg #(
    parameter int SLOTS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             new_level,
    input  logic [SLOTS-1:0] mask,
    output logic [SLOTS-1:0] word,
    output logic             level
);
    logic [SLOTS-1:0] word_next;

    // Blend: masked slots take the new level, the rest keep the old one.
    always_comb begin
        if (wr) word_next = (mask & {SLOTS{new_level}}) | (~mask & {SLOTS{level}});
        else    word_next = {SLOTS{level}};
    end

    // Register level and word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= 1'b0;
            word  <= '0;
        end else begin
            if (wr) level <= new_level;
            word <= word_next;
        end
    end

    // After a cycle without a write the word is uniform.
    assert_uniform_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr) |-> (word == '0 || word == '1));
endmodule

// File: rtl/enable_reg.sv
// Module: output-enable flag, loaded from one data bit on a write.
// Synchronous active-low reset clears it.
module enable_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic d,
    output logic q
);
    // Load the flag on a write; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= 1'b0;
        else if (wr) q <= d;
    end

    // Flag moves only when written.
    assert_enable_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr) |-> $stable(q));
endmodule

// File: rtl/fine_ttl_out.sv
// Module: top of the fine-timestamp TTL output. Decodes strobed commands,
// places level changes at a sub-cycle slot of the serializer word and keeps
// the output-enable flag. Assumes one command per strobed cycle; the word
// is registered, so a change appears one cycle after its strobe.
module fine_ttl_out
    import fine_ttl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_stb,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [FINE_W-1:0] cmd_fine,
    output logic [SLOTS-1:0]  ser_word,
    output logic              out_en
);
    logic             level_wr;
    logic             enable_wr;
    logic             level_q;
    logic [SLOTS-1:0] slot_mask;

    // Address decode for the two writable items.
    always_comb begin
        level_wr  = cmd_stb && (cmd_addr == CMD_LEVEL);
        enable_wr = cmd_stb && (cmd_addr == CMD_ENABLE);
    end

    fine_slot_mask #(.FINE_W(FINE_W)) u_mask (
        .fine        (cmd_fine),
        .at_or_after (slot_mask)
    );

    level_word_reg #(.SLOTS(SLOTS)) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (level_wr),
        .new_level (cmd_data[0]),
        .mask      (slot_mask),
        .word      (ser_word),
        .level     (level_q)
    );

    enable_reg u_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (enable_wr),
        .d     (cmd_data[0]),
        .q     (out_en)
    );

    // Reset leaves a low word and a cleared enable.
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ser_word == '0 && !out_en));

    // The slot named by the fine timestamp carries the new level.
    assert_fine_slot_new_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_stb && cmd_addr == 2'd0) |-> ser_word[$past(cmd_fine)] == $past(cmd_data[0]));

    // Earliest slot keeps the old level when the change is later than slot 0.
    assert_early_slot_old_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_stb && cmd_addr == 2'd0) && $past(cmd_fine) != '0)
        |-> ser_word[0] == $past(ser_word[SLOTS-1]));

    // Enable write lands one cycle after its strobe.
    assert_enable_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_stb && cmd_addr == 2'd1) |-> out_en == $past(cmd_data[0]));

    // Unused addresses touch neither level nor enable.
    assert_ignore_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_stb && cmd_addr[1]) |-> (ser_word == {SLOTS{$past(ser_word[SLOTS-1])}} && $stable(out_en)));

    // Level register always matches the latest slot of the word.
    assert_level_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ser_word[SLOTS-1] == level_q);
endmodule

// File: tb/fine_ttl_out_tb.sv
// Bench: behavioural reference model compared on every clock, plus
// targeted checks on the word values the requirements name.
module fine_ttl_out_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_stb = 1'b0;
    logic [1:0] cmd_addr = '0;
    logic [1:0] cmd_data = '0;
    logic [2:0] cmd_fine = '0;
    logic [7:0] ser_word;
    logic       out_en;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string cur_req = "R1";

    logic [7:0] m_word  = '0;
    logic       m_level = 1'b0;
    logic       m_oe    = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    fine_ttl_out u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .cmd_fine(cmd_fine), .ser_word(ser_word), .out_en(out_en)
    );

    // Reference model: slot-by-slot behaviour from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_word = '0; m_level = 1'b0; m_oe = 1'b0;
        end else begin
            if (cmd_stb && cmd_addr == 2'd0) begin
                for (int s = 0; s < 8; s++)
                    m_word[s] = (s < int'(cmd_fine)) ? m_level : cmd_data[0];
                m_level = cmd_data[0];
            end else begin
                m_word = {8{m_level}};
            end
            if (cmd_stb && cmd_addr == 2'd1) m_oe = cmd_data[0];
        end
    end

    // Compare against the model every cycle, away from the active edge.
    always @(negedge clk) begin
        if (!done && rst_n) begin
            n_cmp++;
            if (ser_word !== m_word || out_en !== m_oe) begin
                n_bad++;
                $display("FAIL %s model: word=%h oe=%b expected word=%h oe=%b",
                         cur_req, ser_word, out_en, m_word, m_oe);
            end
        end
    end

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One strobed write; returns at the negedge after the capturing edge.
    task automatic wr(input logic [1:0] a, input logic d, input logic [2:0] f);
        cmd_addr = a; cmd_data = {1'b0, d}; cmd_fine = f; cmd_stb = 1'b1;
        @(negedge clk);
        cmd_stb = 1'b0;
    endtask

    function automatic logic [7:0] mix(input logic old_l, input logic new_l, input int f);
        logic [7:0] w;
        for (int s = 0; s < 8; s++) w[s] = (s < f) ? old_l : new_l;
        return w;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        check("R1 reset", {out_en, ser_word}, 9'h000);

        cur_req = "R7";
        wr(2'd1, 1'b1, 3'd0);
        check("R7 enable set", {out_en, ser_word}, {1'b1, 8'h00});

        cur_req = "R2";
        wr(2'd0, 1'b1, 3'd3);
        check("R2 rise at 3", {1'b0, ser_word}, 9'h0F8);
        @(negedge clk);
        cur_req = "R3";
        check("R3 steady high", {out_en, ser_word}, 9'h1FF);

        cur_req = "R4";
        wr(2'd0, 1'b0, 3'd0);
        check("R4 fall at 0", {1'b0, ser_word}, 9'h000);
        @(negedge clk);
        check("R3 steady low", {1'b0, ser_word}, 9'h000);

        cur_req = "R5";
        wr(2'd0, 1'b1, 3'd7);
        check("R5 rise at 7", {1'b0, ser_word}, 9'h080);

        cur_req = "R8";
        wr(2'd2, 1'b0, 3'd0);
        check("R8 addr 2 ignored", {out_en, ser_word}, 9'h1FF);
        wr(2'd3, 1'b0, 3'd5);
        check("R8 addr 3 ignored", {out_en, ser_word}, 9'h1FF);
        wr(2'd1, 1'b0, 3'd0);
        check("R8 enable write keeps level", {out_en, ser_word}, 9'h0FF);

        cur_req = "R6";
        cmd_addr = 2'd0; cmd_data = 2'b00; cmd_fine = 3'd4; cmd_stb = 1'b1;
        @(negedge clk);
        check("R6 held first", {1'b0, ser_word}, 9'h00F);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R6 held no retrigger", {1'b0, ser_word}, 9'h000);
        end
        cmd_stb = 1'b0;

        cur_req = "R2";
        for (int f = 0; f < 8; f++) begin
            wr(2'd0, 1'b1, 3'(f));
            check("R2 rise sweep", {1'b0, ser_word}, {1'b0, mix(1'b0, 1'b1, f)});
            wr(2'd0, 1'b0, 3'(f));
            check("R2 fall sweep", {1'b0, ser_word}, {1'b0, mix(1'b1, 1'b0, f)});
        end
        cur_req = "R7";
        wr(2'd0, 1'b1, 3'd2);
        check("R7 level write keeps enable", {out_en, ser_word}, 9'h0FC);

        cur_req = "R1";
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 re-reset", {out_en, ser_word}, 9'h000);
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule